// File: doc/BRIEF.md
# Accumulator Requantization Unit

This block takes the wide signed sum produced by a convolution datapath and turns it back into a 16-bit signed activation with 15 fraction bits, ready for the next layer. Each accepted accumulator word is scaled by a per-layer unsigned multiplier and then shifted right by a per-layer amount. The shift rounds to nearest. The result is then clamped to the 16-bit signed range. A rectifier mode can also force negative results to zero. The sum is 41 bits, with its binary point 30 bits above the least significant bit.

Both data sides are valid/ready streams. A word moves on the input when `in_valid` and `in_ready` are both high at a rising edge. A word moves on the output when `out_valid` and `out_ready` are both high at a rising edge. The three pipeline stages advance together. They freeze whenever the output holds a word that the consumer has not taken, and `in_ready` drops low at the same time. Nothing is dropped or duplicated under back-pressure.

The multiplier, the shift and the rectifier mode come from a plain configuration port. A write takes effect only when the unit is idle.

Top module: `requant_unit`

## Requirements
- R1: For shift s in 1..56, multiplier M and accumulator A, the output equals floor((A*M + 2^(s-1)) / 2^s). This is round half up on the two's-complement value, so -1.5 gives -1 and 1.5 gives 2.
- R2: With s = 0, no rounding term is added and the output is A*M, clamped as in R3.
- R3: A scaled value above 32767 gives 0x7FFF and one below -32768 gives 0x8000. Values inside the range pass unchanged, and the high bits are never simply dropped.
- R4: When the rectifier bit `cfg_relu` = 1 is in force, any negative scaled value gives 0x0000. Non-negative values are unaffected.
- R5: With `out_ready` held high, a word accepted at edge k appears on `out_valid`/`out_data` after edge k+2, which is three cycles of latency. One word can be accepted every cycle. `in_ready` is high whenever `out_valid` is low.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_data` holds its value and `in_ready` is low. Words then leave in their order of arrival.
- R7: A configuration write (`cfg_we` high at an edge) is captured only if no stage holds a word and `in_valid` is low. Otherwise it is ignored and later results use the previous settings.
- R8: A written shift above 56 is stored and applied as 56.
- R9: Reset clears all stages, so `out_valid` = 0 and `in_ready` = 1. Reset also sets M = 1, s = 0 and the rectifier off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mult | input | 16 | Unsigned scale multiplier M |
| cfg_shift | input | 6 | Right-shift amount s |
| cfg_relu | input | 1 | 1 selects the rectifier mode |
| in_valid | input | 1 | Accumulator word offered |
| in_ready | output | 1 | Unit can take a word this cycle |
| in_acc | input | 41 | Signed accumulator word |
| out_valid | output | 1 | Result word offered |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 16 | Signed 16-bit requantized activation |

## Verification
A wrong rounding bias or a wrong shift stage shows up as an off-by-one or a scaled-wrong code on `out_data`. It appears exactly three cycles after the word is accepted, so the bench compares every result against a model evaluated at that point. A broken stall path shows up within the first held cycle. It appears as `out_data` changing or a word vanishing from the ordered stream. A configuration register that is loaded while busy changes the result of the very next word sent after the drain, which the bench checks against the old settings.

// File: rtl/requant_pkg.sv
package requant_pkg;
  typedef enum logic {ACT_LINEAR = 1'b0, ACT_RELU = 1'b1} act_mode_e;

  localparam int DEF_ACC_W     = 41;
  localparam int DEF_MULT_W    = 16;
  localparam int DEF_SHIFT_W   = 6;
  localparam int DEF_OUT_W     = 16;
  localparam int DEF_SHIFT_MAX = 56;
endpackage

// File: rtl/requant_cfg.sv
module requant_cfg
  import requant_pkg::*;
#(
  parameter int MULT_W    = DEF_MULT_W,
  parameter int SHIFT_W   = DEF_SHIFT_W,
  parameter int SHIFT_MAX = DEF_SHIFT_MAX
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic               busy,
  input  logic [MULT_W-1:0]  mult_in,
  input  logic [SHIFT_W-1:0] shift_in,
  input  logic               relu_in,
  output logic [MULT_W-1:0]  mult_q,
  output logic [SHIFT_W-1:0] shift_q,
  output act_mode_e          mode_q
);
  localparam logic [SHIFT_W-1:0] SHIFT_CAP = SHIFT_W'(SHIFT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mult_q  <= MULT_W'(1);
      shift_q <= '0;
      mode_q  <= ACT_LINEAR;
    end else if (we && !busy) begin
      mult_q  <= mult_in;
      shift_q <= (shift_in > SHIFT_CAP) ? SHIFT_CAP : shift_in;
      mode_q  <= relu_in ? ACT_RELU : ACT_LINEAR;
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(mult_q) && $stable(shift_q) && $stable(mode_q))); // R7

  AST_SHIFT_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    shift_q <= SHIFT_CAP); // R8
endmodule

// File: rtl/requant_mul.sv
module requant_mul
  import requant_pkg::*;
#(
  parameter int ACC_W  = DEF_ACC_W,
  parameter int MULT_W = DEF_MULT_W,
  localparam int PROD_W = ACC_W + MULT_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic                     in_valid,
  input  logic signed [ACC_W-1:0]  acc,
  input  logic [MULT_W-1:0]        mult,
  output logic                     v_q,
  output logic signed [PROD_W-1:0] prod_q
);
  logic signed [MULT_W:0]   mult_s;
  logic signed [PROD_W-1:0] prod_d;

  always_comb begin
    mult_s = {1'b0, mult};
    prod_d = acc * mult_s;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      prod_q <= '0;
    end else if (adv) begin
      v_q    <= in_valid;
      prod_q <= prod_d;
    end
  end
endmodule

// File: rtl/requant_round.sv
module requant_round
  import requant_pkg::*;
#(
  parameter int W       = DEF_ACC_W + DEF_MULT_W + 1,
  parameter int SHIFT_W = DEF_SHIFT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  input  logic                v_in,
  input  logic signed [W-1:0] prod,
  input  logic [SHIFT_W-1:0]  shift,
  output logic                v_q,
  output logic signed [W-1:0] val_q
);
  logic signed [W-1:0] bias;
  logic signed [W-1:0] biased;
  logic signed [W-1:0] shifted;

  always_comb begin
    if (shift == '0) bias = '0;
    else             bias = W'(1) << (shift - SHIFT_W'(1));
    biased  = prod + bias;
    shifted = biased >>> shift;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      val_q <= '0;
    end else if (adv) begin
      v_q   <= v_in;
      val_q <= shifted;
    end
  end
endmodule

// File: rtl/requant_sat.sv
module requant_sat
  import requant_pkg::*;
#(
  parameter int W     = DEF_ACC_W + DEF_MULT_W + 1,
  parameter int OUT_W = DEF_OUT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv,
  input  logic                    v_in,
  input  logic signed [W-1:0]     val,
  input  act_mode_e               mode,
  output logic                    v_q,
  output logic signed [OUT_W-1:0] res_q
);
  localparam logic signed [W-1:0] POS_LIM = (W'(1) << (OUT_W - 1)) - W'(1);
  localparam logic signed [W-1:0] NEG_LIM = ~POS_LIM;

  logic signed [OUT_W-1:0] res_d;

  always_comb begin
    if (mode == ACT_RELU && val < 0) res_d = '0;
    else if (val > POS_LIM)          res_d = POS_LIM[OUT_W-1:0];
    else if (val < NEG_LIM)          res_d = NEG_LIM[OUT_W-1:0];
    else                             res_d = val[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      res_q <= '0;
    end else if (adv) begin
      v_q   <= v_in;
      res_q <= res_d;
    end
  end

  AST_RELU_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && mode == ACT_RELU) |-> !res_q[OUT_W-1]); // R4

  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && v_in && val >= 0) |=> !res_q[OUT_W-1]); // R3
endmodule

// File: rtl/requant_unit.sv
module requant_unit
  import requant_pkg::*;
#(
  parameter int ACC_W     = DEF_ACC_W,
  parameter int MULT_W    = DEF_MULT_W,
  parameter int SHIFT_W   = DEF_SHIFT_W,
  parameter int OUT_W     = DEF_OUT_W,
  parameter int SHIFT_MAX = DEF_SHIFT_MAX
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [MULT_W-1:0]  cfg_mult,
  input  logic [SHIFT_W-1:0] cfg_shift,
  input  logic               cfg_relu,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [ACC_W-1:0]   in_acc,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [OUT_W-1:0]   out_data
);
  localparam int PROD_W = ACC_W + MULT_W + 1;

  logic [MULT_W-1:0]        mult_q;
  logic [SHIFT_W-1:0]       shift_q;
  act_mode_e                mode_q;
  logic                     adv, busy;
  logic                     v1, v2, v3;
  logic signed [PROD_W-1:0] prod1, val2;
  logic signed [OUT_W-1:0]  res3;

  assign adv      = !v3 || out_ready;
  assign in_ready = adv;
  assign busy     = v1 || v2 || v3 || in_valid;

  requant_cfg #(.MULT_W(MULT_W), .SHIFT_W(SHIFT_W), .SHIFT_MAX(SHIFT_MAX)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .busy(busy),
    .mult_in(cfg_mult), .shift_in(cfg_shift), .relu_in(cfg_relu),
    .mult_q(mult_q), .shift_q(shift_q), .mode_q(mode_q)
  );

  requant_mul #(.ACC_W(ACC_W), .MULT_W(MULT_W)) u_mul (
    .clk(clk), .rst_n(rst_n), .adv(adv), .in_valid(in_valid),
    .acc(signed'(in_acc)), .mult(mult_q), .v_q(v1), .prod_q(prod1)
  );

  requant_round #(.W(PROD_W), .SHIFT_W(SHIFT_W)) u_round (
    .clk(clk), .rst_n(rst_n), .adv(adv), .v_in(v1), .prod(prod1),
    .shift(shift_q), .v_q(v2), .val_q(val2)
  );

  requant_sat #(.W(PROD_W), .OUT_W(OUT_W)) u_sat (
    .clk(clk), .rst_n(rst_n), .adv(adv), .v_in(v2), .val(val2),
    .mode(mode_q), .v_q(v3), .res_q(res3)
  );

  assign out_valid = v3;
  assign out_data  = res3;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6

  AST_READY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R5
endmodule

// File: tb/requant_unit_test.sv
module requant_unit_test;
  localparam int CLK_P = 10;

  typedef struct packed {
    longint      acc;
    logic [15:0] m;
    logic [5:0]  s;
    logic        relu;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{64'sd1073741824,  16'd1,     6'd16, 1'b0, 16'h4000},  // R1 +0.5
    '{-64'sd1073741824, 16'd1,     6'd16, 1'b0, 16'hC000},  // R1 -0.5
    '{64'sd3,           16'd1,     6'd1,  1'b0, 16'h0002},  // R1 1.5 -> 2
    '{-64'sd3,          16'd1,     6'd1,  1'b0, 16'hFFFF},  // R1 -1.5 -> -1
    '{64'sd5,           16'd3,     6'd2,  1'b0, 16'h0004},  // R1
    '{64'sd1073741824,  16'd1,     6'd15, 1'b0, 16'h7FFF},  // R3 high
    '{-64'sd1073741824, 16'd1,     6'd15, 1'b0, 16'h8000},  // R3 exact min
    '{-64'sd4294967296, 16'd1,     6'd15, 1'b0, 16'h8000},  // R3 low
    '{64'sd1000,        16'd7,     6'd0,  1'b0, 16'h1B58},  // R2
    '{-64'sd3,          16'd1,     6'd1,  1'b1, 16'h0000},  // R4 negative
    '{64'sd3,           16'd1,     6'd1,  1'b1, 16'h0002},  // R4 positive
    '{64'sd1099511627775, 16'd65535, 6'd63, 1'b0, 16'h0001}, // R8 cap
    '{-64'sd1099511627776, 16'd65535, 6'd56, 1'b0, 16'hFFFF} // R1 widest
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_mult = '0;
  logic [5:0]  cfg_shift = '0;
  logic        cfg_relu = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [40:0] in_acc = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  requant_unit uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mult(cfg_mult),
    .cfg_shift(cfg_shift), .cfg_relu(cfg_relu), .in_valid(in_valid),
    .in_ready(in_ready), .in_acc(in_acc), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [15:0] model(longint a, longint m, int s, bit relu);
    longint p;
    int se;
    se = (s > 56) ? 56 : s;
    p = a * m;
    if (se > 0) p = (p + (64'sd1 <<< (se - 1))) >>> se;
    if (relu && p < 0) p = 0;
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return p[15:0];
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic cfg_write(logic [15:0] m, logic [5:0] s, logic r);
    cfg_we = 1'b1; cfg_mult = m; cfg_shift = s; cfg_relu = r;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_one(longint a, output logic [15:0] res);
    in_valid = 1'b1; in_acc = a[40:0];
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check("R5 no early valid", {15'd0, out_valid}, 16'd0);
    @(negedge clk);
    check("R5 valid after three", {15'd0, out_valid}, 16'd1);
    res = out_data;
    @(negedge clk);
  endtask

  task automatic push(longint a);
    in_valid = 1'b1; in_acc = a[40:0];
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] r;
    longint sa [6];
    int got;
    int first_k;
    sa = '{64'sd1048576, -64'sd1048576, 64'sd12345, -64'sd777, 64'sd549755813887, 64'sd0};

    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 out_valid", {15'd0, out_valid}, 16'd0);
    check("R9 in_ready", {15'd0, in_ready}, 16'd1);
    rst_n = 1'b1;
    @(negedge clk);
    run_one(64'sd1234, r);
    check("R9 default M=1 s=0", r, 16'h04D2);

    // Vector table: R1 R2 R3 R4 R8
    for (int i = 0; i < NV; i++) begin
      cfg_write(VECS[i].m, VECS[i].s, VECS[i].relu);
      run_one(VECS[i].acc, r);
      check($sformatf("R1/R2/R3/R4/R8 vector %0d", i), r, VECS[i].exp);
      check($sformatf("model agrees vector %0d", i), r,
            model(VECS[i].acc, VECS[i].m, VECS[i].s, VECS[i].relu));
    end

    // R5 back-to-back stream
    cfg_write(16'd3, 6'd4, 1'b0);
    got = 0; first_k = -1;
    for (int k = 0; k < 10; k++) begin
      if (out_valid) begin
        if (first_k < 0) first_k = k;
        if (got < 6) check("R5 stream data", out_data, model(sa[got], 3, 4, 0));
        got++;
      end
      in_valid = (k < 6);
      in_acc = (k < 6) ? sa[k][40:0] : '0;
      @(negedge clk);
    end
    in_valid = 1'b0;
    check("R5 stream count", 16'(got), 16'd6);
    check("R5 stream first output cycle", 16'(first_k), 16'd3);

    // R6 back-pressure, R7 write while busy
    out_ready = 1'b0;
    push(sa[0]); push(sa[1]); push(sa[2]);
    check("R6 valid held", {15'd0, out_valid}, 16'd1);
    check("R6 in_ready low", {15'd0, in_ready}, 16'd0);
    cfg_write(16'd9, 6'd1, 1'b1);
    @(negedge clk);
    check("R6 data stable", out_data, model(sa[0], 3, 4, 0));
    check("R6 in_ready still low", {15'd0, in_ready}, 16'd0);
    out_ready = 1'b1;
    for (int j = 0; j < 3; j++) begin
      check("R6 ordered drain valid", {15'd0, out_valid}, 16'd1);
      check("R6 ordered drain data", out_data, model(sa[j], 3, 4, 0));
      @(negedge clk);
    end
    check("R6 drained", {15'd0, out_valid}, 16'd0);
    run_one(-64'sd777, r);
    check("R7 write while busy ignored", r, model(-777, 3, 4, 0));

    // R7 write alongside in_valid ignored
    in_valid = 1'b1; in_acc = 41'd100;
    cfg_we = 1'b1; cfg_mult = 16'd50; cfg_shift = 6'd0; cfg_relu = 1'b0;
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R7 concurrent write word", out_data, model(100, 3, 4, 0));
    @(negedge clk);
    run_one(64'sd100, r);
    check("R7 concurrent write ignored", r, model(100, 3, 4, 0));

    // R9 reset mid-flight
    in_valid = 1'b1; in_acc = 41'd5;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset clears valid", {15'd0, out_valid}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R9 stays empty", {15'd0, out_valid}, 16'd0);
    run_one(-64'sd40000, r);
    check("R9 default config after reset", r, 16'h8000);

    finish_run();
  end
endmodule